// File: doc/BRIEF.md
# Single-Wire Bus Mode and Wake Controller

This block is the digital control core of a single-wire CAN physical layer. Two host mode pins select one of four operating states: sleep, high-voltage wake-up transmit, high-speed transmit and normal transmit. From the selected state, the transmit data and the bus comparator bits, the block produces the controls for the analog bus driver. These are a stage enable, a dominant-drive command, a high-voltage level enable and a slew-shaping enable. It also produces the open-drain receive output and the load-switch control. The analog driver, the comparators, the filters and the thresholds sit outside the block.

A regulator-enable output powers the host. In sleep, a filtered high-voltage wake level on the bus raises this output. It stays high for a long hold interval, so that the host can boot and select a non-sleep mode. If the host has not done so when the interval ends, the output falls, even when the bus is still at the wake level. All timers count a 500 kHz tick, which reaches the block as a clock enable. Undervoltage silences both the driver and the receiver. Loss of ground opens the load switch.

All pins are plain level signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. The mode pins and the two comparator bits pass through synchronizers. The transmit pin and the fault flags are registered once.

Top module: `swbus_mode_ctrl`

## Requirements
- R1: The mode code {mode0, mode1} decodes as 00 sleep, 01 high-voltage wake-up, 10 high-speed and 11 normal. Mode pins that are left low give sleep. In sleep, drv_en, drv_dom and hv_en stay 0.
- R2: Outside sleep, drv_dom is the inverse of txd. txd=0 drives dominant (drv_dom=1) and txd=1 leaves the bus recessive (drv_dom=0). drv_dom changes one clock after txd.
- R3: shape_en is 1 in normal and wake-up modes and 0 in high-speed mode. hv_en is 1 only in wake-up mode.
- R4: After txd returns to 1, drv_en stays 1 for DRV_HOLD_TICKS ticks and then falls. drv_dom falls at once.
- R5: Outside sleep, rx_rel is 0 when bus_dom=1 and 1 when bus_dom=0.
- R6: In sleep, rx_rel is 1 unless a wake level is detected. While it is detected, rx_rel follows the bus as in R5. When the wake level ends, rx_rel keeps following the bus for RX_RELEASE_TICKS ticks and is then released to 1.
- R7: bus_wake counts as detected only after it has been high for WAKE_STABLE_TICKS consecutive ticks. A shorter pulse changes neither reg_en nor rx_rel.
- R8: In sleep with reg_en=0, a new wake detection sets reg_en to 1 and restarts the hold interval.
- R9: In sleep, the hold interval counts HOLD_TICKS ticks from the wake detection or from sleep entry. When it ends, reg_en falls, even if bus_wake is still high. The interval advances only on cycles where tick_en=1.
- R10: While the mode code is not sleep, reg_en is 1 and the hold interval is reloaded.
- R11: uv_flag=1 forces drv_en, drv_dom, hv_en and shape_en to 0 and rx_rel to 1.
- R12: load_close is 0 when lgnd_flag=1 and 1 otherwise, one clock later.
- R13: After reset, drv_en=0, rx_rel=1, load_close=1 and reg_en=1, with a full hold interval armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 500 kHz timer rate |
| txd | input | 1 | Transmit data, 0 = dominant |
| mode0 | input | 1 | Mode code, upper bit |
| mode1 | input | 1 | Mode code, lower bit |
| bus_dom | input | 1 | Comparator: bus above the normal dominant threshold |
| bus_wake | input | 1 | Comparator: bus above the wake-level threshold |
| uv_flag | input | 1 | Supply undervoltage |
| lgnd_flag | input | 1 | Loss of module ground |
| drv_en | output | 1 | Bus driver stage enable |
| drv_dom | output | 1 | Drive bus dominant |
| hv_en | output | 1 | Select high-voltage dominant level |
| shape_en | output | 1 | Enable edge waveshaping |
| rx_rel | output | 1 | Receive output, 1 = released (high), 0 = pulled low |
| reg_en | output | 1 | Host regulator enable |
| load_close | output | 1 | Load switch closed |

## Verification
The main function is driven with every mode code, each with the node transmitting dominant, the node recessive, and a foreign dominant level on the bus. These patterns separate the drive, shaping and high-voltage decodes per mode. They also separate the node's own drive from the received bus state. Sleep is tried without a wake level, with a sustained wake level, with a pulse shorter than the stability window and with a wake level stuck high. These show whether the filter, the receive gating and the hold timeout act independently. Further runs stall the tick, let the host take over during the hold and apply the undervoltage and ground-loss flags. These confirm that the timers count only ticks, that a host mode overrides the timeout and that the fault overrides take priority.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

  // Encoding is {mode0, mode1}
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_HVWU  = 2'b01,
    MODE_FAST  = 2'b10,
    MODE_NORM  = 2'b11
  } swmode_e;

  function automatic swmode_e decode_mode(input logic m0, input logic m1);
    return swmode_e'({m0, m1});
  endfunction

endpackage

// File: rtl/swbus_sync.sv
module swbus_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/swbus_wake_filter.sv
module swbus_wake_filter #(
  parameter int STABLE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wake_s,
  output logic wake_det
);

  localparam int CW = $clog2(STABLE_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_TICKS);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      wake_det <= 1'b0;
    end else if (!wake_s) begin
      run_cnt  <= '0;
      wake_det <= 1'b0;
    end else begin
      if (tick && run_cnt != LIMIT) run_cnt <= run_cnt + CW'(1);
      wake_det <= (run_cnt == LIMIT);
    end
  end

  // R7: detection is only reported while the synchronized level was high
  p_det_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_det |-> $past(wake_s));

endmodule

// File: rtl/swbus_wake_timer.sv
module swbus_wake_timer #(
  parameter int HOLD_TICKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic awake,
  input  logic wake_det,
  output logic reg_en
);

  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_TICKS);

  logic [HW-1:0] hold_cnt;
  logic          det_q;
  logic          wake_edge;

  assign wake_edge = wake_det & ~det_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= HOLD_LOAD;
      reg_en   <= 1'b1;
      det_q    <= 1'b0;
    end else begin
      det_q <= wake_det;
      if (awake) begin
        hold_cnt <= HOLD_LOAD;
        reg_en   <= 1'b1;
      end else if (wake_edge && !reg_en) begin
        hold_cnt <= HOLD_LOAD;
        reg_en   <= 1'b1;
      end else begin
        if (tick && hold_cnt != '0) hold_cnt <= hold_cnt - HW'(1);
        if (hold_cnt == '0) reg_en <= 1'b0;
      end
    end
  end

  // R10: a host-selected mode keeps the regulator on
  p_awake_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    awake |=> reg_en);

  // R8: the regulator only turns on from a wake edge or a host mode
  p_reg_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en) |-> $past(awake || wake_edge));

  // R9: the regulator only turns off while in sleep
  p_reg_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_en) |-> $past(!awake));

endmodule

// File: rtl/swbus_txrx.sv
module swbus_txrx
  import swbus_pkg::*;
#(
  parameter int DRV_HOLD_TICKS   = 8,
  parameter int RX_RELEASE_TICKS = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  swmode_e mode,
  input  logic    txd,
  input  logic    bus_dom_s,
  input  logic    wake_det,
  input  logic    uv,
  output logic    drv_en,
  output logic    drv_dom,
  output logic    hv_en,
  output logic    shape_en,
  output logic    rx_rel
);

  localparam int DW = $clog2(DRV_HOLD_TICKS + 1);
  localparam int RW = $clog2(RX_RELEASE_TICKS + 1);
  localparam logic [DW-1:0] DRV_LOAD = DW'(DRV_HOLD_TICKS);
  localparam logic [RW-1:0] RX_LOAD  = RW'(RX_RELEASE_TICKS);

  logic          awake;
  logic          active;
  logic          rx_pass;
  logic [DW-1:0] drv_cnt;
  logic [RW-1:0] rx_cnt;

  assign awake   = (mode != MODE_SLEEP);
  assign active  = awake & ~uv;
  assign rx_pass = awake | wake_det | (rx_cnt != '0);

  // driver hold after a recessive edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         drv_cnt <= '0;
    else if (!txd)                      drv_cnt <= DRV_LOAD;
    else if (tick && drv_cnt != '0)     drv_cnt <= drv_cnt - DW'(1);
  end

  // receive pass-through window after the wake level ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rx_cnt <= '0;
    else if (wake_det)                  rx_cnt <= RX_LOAD;
    else if (tick && rx_cnt != '0)      rx_cnt <= rx_cnt - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_en   <= 1'b0;
      drv_dom  <= 1'b0;
      hv_en    <= 1'b0;
      shape_en <= 1'b0;
      rx_rel   <= 1'b1;
    end else begin
      drv_en   <= active & (~txd | (drv_cnt != '0));
      drv_dom  <= active & ~txd;
      hv_en    <= active & (mode == MODE_HVWU);
      shape_en <= active & ((mode == MODE_NORM) | (mode == MODE_HVWU));
      rx_rel   <= uv | ~rx_pass | ~bus_dom_s;
    end
  end

  // R11: undervoltage silences driver and receiver
  p_uv_lockout_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (!drv_en && !drv_dom && rx_rel));

  // R2: dominant drive only follows a low transmit input
  p_dom_from_txd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dom |-> $past(!txd));

  // R1: no drive in sleep
  p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP) |=> (!drv_en && !drv_dom && !hv_en));

  // R3: high-voltage level and shaping never contradict
  p_hv_shaped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |-> shape_en);

endmodule

// File: rtl/swbus_mode_ctrl.sv
module swbus_mode_ctrl
  import swbus_pkg::*;
#(
  parameter int SYNC_STAGES       = 2,
  parameter int WAKE_STABLE_TICKS = 16,
  parameter int HOLD_TICKS        = 250000,
  parameter int DRV_HOLD_TICKS    = 8,
  parameter int RX_RELEASE_TICKS  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic txd,
  input  logic mode0,
  input  logic mode1,
  input  logic bus_dom,
  input  logic bus_wake,
  input  logic uv_flag,
  input  logic lgnd_flag,
  output logic drv_en,
  output logic drv_dom,
  output logic hv_en,
  output logic shape_en,
  output logic rx_rel,
  output logic reg_en,
  output logic load_close
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0] sync_q;
  logic             m0_s, m1_s, dom_s, wake_s;
  logic             wake_det;
  logic             uv_q;
  swmode_e          mode;

  swbus_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mode0, mode1, bus_dom, bus_wake}),
    .q     (sync_q)
  );

  assign {m0_s, m1_s, dom_s, wake_s} = sync_q;
  assign mode = decode_mode(m0_s, m1_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q       <= 1'b0;
      load_close <= 1'b1;
    end else begin
      uv_q       <= uv_flag;
      load_close <= ~lgnd_flag;
    end
  end

  swbus_wake_filter #(.STABLE_TICKS(WAKE_STABLE_TICKS)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .wake_s   (wake_s),
    .wake_det (wake_det)
  );

  swbus_wake_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .awake    (mode != MODE_SLEEP),
    .wake_det (wake_det),
    .reg_en   (reg_en)
  );

  swbus_txrx #(
    .DRV_HOLD_TICKS   (DRV_HOLD_TICKS),
    .RX_RELEASE_TICKS (RX_RELEASE_TICKS)
  ) u_txrx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .mode      (mode),
    .txd       (txd),
    .bus_dom_s (dom_s),
    .wake_det  (wake_det),
    .uv        (uv_q),
    .drv_en    (drv_en),
    .drv_dom   (drv_dom),
    .hv_en     (hv_en),
    .shape_en  (shape_en),
    .rx_rel    (rx_rel)
  );

  // R12: ground loss opens the load switch, otherwise it is closed
  p_load_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lgnd_flag |=> !load_close);
  p_load_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !lgnd_flag |=> load_close);

endmodule

// File: tb/swbus_mode_ctrl_tb.sv
module swbus_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD   = 40;
  localparam int DHOLD  = 3;
  localparam int RXREL  = 3;
  localparam int STABLE = 3;
  localparam int NVEC   = 12;

  // vector = {m0,m1,txd,dom,wake,uv,lg, drv_en,drv_dom,hv_en,shape_en,rx_rel,load_close}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b1101000_110101,  // normal, own dominant
    13'b1110000_000111,  // normal, recessive
    13'b1001000_110001,  // high-speed, own dominant
    13'b1010000_000011,  // high-speed, recessive
    13'b0101000_111101,  // wake-up mode, own dominant
    13'b0111000_001101,  // wake-up mode, foreign dominant
    13'b1101010_000011,  // normal, undervoltage
    13'b1111001_000100,  // normal, foreign dominant, ground loss
    13'b0001000_000011,  // sleep, no wake, txd low ignored
    13'b0001100_000001,  // sleep, wake, bus dominant
    13'b0010100_000011,  // sleep, wake, bus recessive
    13'b1110000_000111   // back to normal
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic txd = 1'b1;
  logic mode0 = 1'b0, mode1 = 1'b0;
  logic bus_dom = 1'b0, bus_wake = 1'b0;
  logic uv_flag = 1'b0, lgnd_flag = 1'b0;
  logic drv_en, drv_dom, hv_en, shape_en, rx_rel, reg_en, load_close;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swbus_mode_ctrl #(
    .SYNC_STAGES       (2),
    .WAKE_STABLE_TICKS (STABLE),
    .HOLD_TICKS        (HOLD),
    .DRV_HOLD_TICKS    (DHOLD),
    .RX_RELEASE_TICKS  (RXREL)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .txd        (txd),
    .mode0      (mode0),
    .mode1      (mode1),
    .bus_dom    (bus_dom),
    .bus_wake   (bus_wake),
    .uv_flag    (uv_flag),
    .lgnd_flag  (lgnd_flag),
    .drv_en     (drv_en),
    .drv_dom    (drv_dom),
    .hv_en      (hv_en),
    .shape_en   (shape_en),
    .rx_rel     (rx_rel),
    .reg_en     (reg_en),
    .load_close (load_close)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    // R13 reset state; R1 pins low give sleep, no drive
    chk("R13 reset drv_en", {5'b0, drv_en}, 6'd0);
    chk("R13 reset rx_rel", {5'b0, rx_rel}, 6'd1);
    chk("R13 reset reg_en", {5'b0, reg_en}, 6'd1);
    chk("R1 reset load_close/hv_en", {4'b0, load_close, hv_en}, 6'b000010);

    // R9 the hold armed by reset expires in sleep
    cyc(29);
    chk("R9 hold before expiry", {5'b0, reg_en}, 6'd1);
    cyc(25);
    chk("R9 hold expired", {5'b0, reg_en}, 6'd0);

    // R10 host mode raises the regulator
    mode0 = 1'b1; mode1 = 1'b1;
    cyc(5);
    chk("R10 host mode reg_en", {5'b0, reg_en}, 6'd1);

    // table: R1 R2 R3 R5 R6 R11 R12
    for (int i = 0; i < NVEC; i++) begin
      {mode0, mode1, txd, bus_dom, bus_wake, uv_flag, lgnd_flag} = VEC[i][12:6];
      cyc(10);
      chk($sformatf("R1/R2/R3/R5/R6/R11/R12 vector %0d", i),
          {drv_en, drv_dom, hv_en, shape_en, rx_rel, load_close}, VEC[i][5:0]);
    end

    // R4 driver hold after recessive edge
    mode0 = 1'b1; mode1 = 1'b1; txd = 1'b0; bus_dom = 1'b0;
    cyc(4);
    txd = 1'b1;
    cyc(1);
    chk("R4 drv held, dom released", {4'b0, drv_en, drv_dom}, 6'b000010);
    cyc(8);
    chk("R4 drv released", {4'b0, drv_en, drv_dom}, 6'b000000);

    // R9 sleep timeout, then R8 wake, then R9 stuck wake still times out
    mode0 = 1'b0; mode1 = 1'b0;
    cyc(60);
    chk("R9 sleep timeout", {5'b0, reg_en}, 6'd0);
    bus_wake = 1'b1;
    cyc(12);
    chk("R8 wake raises reg_en", {5'b0, reg_en}, 6'd1);
    cyc(60);
    chk("R9 stuck wake times out", {5'b0, reg_en}, 6'd0);

    // R7 short wake pulse ignored
    bus_wake = 1'b0; bus_dom = 1'b1;
    cyc(10);
    bus_wake = 1'b1;
    cyc(2);
    bus_wake = 1'b0;
    cyc(10);
    chk("R7 glitch reg_en", {5'b0, reg_en}, 6'd0);
    chk("R7 glitch rx_rel", {5'b0, rx_rel}, 6'd1);

    // R6 receive window in sleep
    bus_wake = 1'b1;
    cyc(12);
    chk("R6 wake rx follows bus", {4'b0, rx_rel, reg_en}, 6'b000001);
    bus_wake = 1'b0;
    cyc(2);
    chk("R6 rx held after wake ends", {5'b0, rx_rel}, 6'd0);
    cyc(12);
    chk("R6 rx released", {5'b0, rx_rel}, 6'd1);

    // R10 host takes over during hold
    mode0 = 1'b0; mode1 = 1'b1;
    cyc(80);
    chk("R10 host keeps reg_en", {5'b0, reg_en}, 6'd1);

    // R9 hold advances only on ticks
    mode0 = 1'b0; mode1 = 1'b0; tick_en = 1'b0;
    cyc(100);
    chk("R9 stalled tick keeps reg_en", {5'b0, reg_en}, 6'd1);
    tick_en = 1'b1;
    cyc(55);
    chk("R9 ticking hold expires", {5'b0, reg_en}, 6'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule